// File: doc/BRIEF.md
# Keyed Configuration Port Decoder

This block is an index/data configuration port on a plain byte-wide I/O bus. An index port and a data port sit at two neighbouring I/O addresses. Software first writes a register number to the index port. It then reads or writes that register through the data port. The port ignores register traffic until software writes a fixed four-byte key to the index port. After the key it stays open until software writes the exit value to the exit register.

Once open, the low index range reaches registers held in the block itself. These are a logical-device selector, a read-only chip identifier and a read-only revision. The high index range goes out on a device bus, together with the device number currently selected. The logical devices behind that bus decode the strobes, the index and the selector, and they return read data combinationally.

Top module: `cfg_port`

## Requirements
- R1: After reset the port is locked, `cfg_open` is 0, no device strobe is active and the index and device-number registers are 0x00.
- R2: Writing 0x87, 0x01, 0x55, 0x55 in that order to the index port (0x2E) opens the port from the clock edge of the fourth write.
- R3: A key byte that does not match restarts the matcher. If that byte is 0x87, it counts as the first key byte. The port stays locked until a complete key has been written.
- R4: While locked, every read of either port returns 0xFF, so both chip-ID bytes read 0xFF. Data-port writes change no register, and no device strobe fires.
- R5: While open, a write to the index port sets the current index, and a read of the index port returns it.
- R6: Index 0x07 is the logical-device number. It is readable and writable through the data port and drives `dev_ldn`. It keeps its value across lock and unlock.
- R7: Indices 0x20 and 0x21 return the high and low bytes of the chip ID. Index 0x22 returns the revision with its upper nibble forced to zero. Writes to these three indices change nothing.
- R8: For indices 0x30 to 0xFF, a data-port write pulses `dev_wr` for that cycle, with `dev_idx`, `dev_ldn` and `dev_wdata` valid. A data-port read pulses `dev_rd` and returns `dev_rdata`.
- R9: Writing 0x02 to index 0x02 locks the port again, and any other value written there does not. Other global indices below 0x30 read 0x00.
- R10: An access to any address other than the two ports has no effect, and a read of such an address returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address of the access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational) |
| cfg_open | output | 1 | High while configuration mode is open |
| dev_ldn | output | 8 | Selected logical-device number |
| dev_idx | output | 8 | Current index toward the devices |
| dev_wdata | output | 8 | Write data toward the devices |
| dev_wr | output | 1 | Device register write strobe |
| dev_rd | output | 1 | Device register read strobe |
| dev_rdata | input | 8 | Read data from the selected device |

## Verification
The bench builds the block with its default parameters. The ports sit at 0x2E and 0x2F, the key is 0x87 0x01 0x55 0x55, the chip ID is 0x8728 and the raw revision is 0xA3. With a nonzero upper revision nibble, a missing mask shows up as a wrong read. The repeated 0x55 and the leading 0x87 in the key make the partial-match restart cases reachable. Random traffic drawn from key bytes, special indices and device indices exercises lock, unlock, exit and bank switching in many orders.

// File: rtl/cfg_port.sv
module cfg_port #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] IDX_PORT  = 16'h002E,
  parameter logic [15:0] DAT_PORT  = 16'h002F,
  parameter logic [31:0] KEY       = 32'h8701_5555,
  parameter logic [15:0] CHIP_ID   = 16'h8728,
  parameter logic [7:0]  CHIP_REV  = 8'hA3,
  parameter logic [7:0]  LDN_IDX   = 8'h07,
  parameter logic [7:0]  EXIT_IDX  = 8'h02,
  parameter logic [7:0]  EXIT_VAL  = 8'h02,
  parameter logic [7:0]  DEV_BASE  = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              cfg_open,
  output logic [7:0]        dev_ldn,
  output logic [7:0]        dev_idx,
  output logic [7:0]        dev_wdata,
  output logic              dev_wr,
  output logic              dev_rd,
  input  logic [7:0]        dev_rdata
);

  localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(IDX_PORT);
  localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(DAT_PORT);
  localparam logic [7:0] KEY_FIRST = KEY[31:24];

  logic       open_q;
  logic [1:0] kpos;
  logic [7:0] idx_q, ldn_q;

  wire hit_idx = io_addr == IDX_A;
  wire hit_dat = io_addr == DAT_A;
  wire wr_idx  = io_wr && hit_idx;
  wire wr_dat  = io_wr && hit_dat;
  wire is_dev  = idx_q >= DEV_BASE;
  wire [7:0] key_byte = 8'(KEY >> {2'd3 - kpos, 3'b000});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      kpos   <= 2'd0;
      idx_q  <= 8'h00;
      ldn_q  <= 8'h00;
    end else if (!open_q) begin
      if (wr_idx) begin
        if (io_wdata == key_byte) begin
          if (kpos == 2'd3) begin
            open_q <= 1'b1;
            kpos   <= 2'd0;
          end else begin
            kpos <= kpos + 2'd1;
          end
        end else begin
          kpos <= (io_wdata == KEY_FIRST) ? 2'd1 : 2'd0;
        end
      end
    end else begin
      if (wr_idx) idx_q <= io_wdata;
      if (wr_dat && idx_q == LDN_IDX) ldn_q <= io_wdata;
      if (wr_dat && idx_q == EXIT_IDX && io_wdata == EXIT_VAL) open_q <= 1'b0;
    end
  end

  always_comb begin
    io_rdata = 8'hFF;
    if (open_q && hit_idx) begin
      io_rdata = idx_q;
    end else if (open_q && hit_dat) begin
      if (is_dev) io_rdata = dev_rdata;
      else begin
        case (idx_q)
          LDN_IDX: io_rdata = ldn_q;
          8'h20:   io_rdata = CHIP_ID[15:8];
          8'h21:   io_rdata = CHIP_ID[7:0];
          8'h22:   io_rdata = {4'h0, CHIP_REV[3:0]};
          default: io_rdata = 8'h00;
        endcase
      end
    end
  end

  assign cfg_open  = open_q;
  assign dev_ldn   = ldn_q;
  assign dev_idx   = idx_q;
  assign dev_wdata = io_wdata;
  assign dev_wr    = open_q && wr_dat && is_dev;
  assign dev_rd    = open_q && io_rd && hit_dat && is_dev;

  // R2: opening only follows a final key byte on the index port
  a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> $past(io_wr && hit_idx && io_wdata == KEY[7:0]));

  // R9: closing only follows the exit write
  a_r9_close_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(open_q) |-> $past(io_wr && hit_dat && idx_q == EXIT_IDX && io_wdata == EXIT_VAL));

  // R6: device number changes only through an open data-port write at index 0x07
  a_r6_ldn_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ldn_q) |-> $past(open_q && io_wr && hit_dat && idx_q == LDN_IDX));

  // R5: index changes only through an open index-port write
  a_r5_idx_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(idx_q) |-> $past(open_q && io_wr && hit_idx));

  // R8: device strobes never coincide with a locked port
  a_r8_dev_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr || dev_rd) |-> (cfg_open && dev_idx >= DEV_BASE));

endmodule

// File: tb/cfg_port_test.sv
`timescale 1ns/1ps
module cfg_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = 8'h0;
  logic [7:0] io_rdata, dev_ldn, dev_idx, dev_wdata, dev_rdata;
  logic cfg_open, dev_wr, dev_rd;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  bit m_open = 0;
  int m_k = 0;
  logic [7:0] m_idx = 8'h00, m_ldn = 8'h00;

  always #2.5 clk = ~clk;

  assign dev_rdata = dev_ldn ^ dev_idx ^ 8'h5A;

  cfg_port uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open),
    .dev_ldn(dev_ldn), .dev_idx(dev_idx), .dev_wdata(dev_wdata),
    .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_rdata(dev_rdata)
  );

  function automatic logic [7:0] key_at(int n);
    case (n)
      0: return 8'h87;
      1: return 8'h01;
      default: return 8'h55;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(logic [15:0] a);
    if (!m_open || (a != 16'h2E && a != 16'h2F)) return 8'hFF;
    if (a == 16'h2E) return m_idx;
    if (m_idx >= 8'h30) return m_ldn ^ m_idx ^ 8'h5A;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return 8'h87;
      8'h21: return 8'h28;
      8'h22: return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d, string tag);
    bit exp_dw;
    exp_dw = m_open && a == 16'h2F && m_idx >= 8'h30;
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    #1;
    check({tag, " dev_wr"}, dev_wr, exp_dw);
    if (exp_dw) check({tag, " dev bus"}, {dev_ldn, dev_idx, dev_wdata}, {m_ldn, m_idx, d});
    // model update
    if (!m_open) begin
      if (a == 16'h2E) begin
        if (d == key_at(m_k)) begin
          if (m_k == 3) begin m_open = 1; m_k = 0; end else m_k++;
        end else m_k = (d == 8'h87) ? 1 : 0;
      end
    end else begin
      if (a == 16'h2E) m_idx = d;
      else if (a == 16'h2F) begin
        if (m_idx == 8'h07) m_ldn = d;
        if (m_idx == 8'h02 && d == 8'h02) m_open = 0;
      end
    end
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, logic [7:0] exp, string tag);
    bit exp_dr;
    exp_dr = m_open && a == 16'h2F && m_idx >= 8'h30;
    io_addr = a; io_rd = 1'b1;
    #1;
    check(tag, io_rdata, exp);
    check({tag, " dev_rd"}, dev_rd, exp_dr);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic unlock(string tag);
    for (int i = 0; i < 4; i++) wr(16'h2E, key_at(i), tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] pool [8];
    void'($urandom(32'd4242));
    pool = '{8'h87, 8'h01, 8'h55, 8'h02, 8'h07, 8'h20, 8'h22, 8'h71};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 open", cfg_open, 1'b0);
    check("R1 strobes", {dev_wr, dev_rd}, 2'b00);
    check("R1 regs", {dev_idx, dev_ldn}, 16'h0000);
    // R4 locked behaviour
    wr(16'h2E, 8'h07, "R4 locked idx");
    wr(16'h2F, 8'h33, "R4 locked data");
    rd(16'h2E, 8'hFF, "R4 locked index read");
    rd(16'h2F, 8'hFF, "R4 locked data read");
    check("R4 ldn unchanged", dev_ldn, 8'h00);
    // R3 broken key then restart on 0x87
    wr(16'h2E, 8'h87, "R3"); wr(16'h2E, 8'h01, "R3");
    wr(16'h2E, 8'h55, "R3"); wr(16'h2E, 8'h00, "R3");
    check("R3 still locked", cfg_open, 1'b0);
    wr(16'h2E, 8'h87, "R3"); wr(16'h2E, 8'h01, "R3");
    wr(16'h2E, 8'h87, "R3"); wr(16'h2E, 8'h01, "R3");
    wr(16'h2E, 8'h55, "R3");
    check("R3 not yet open", cfg_open, 1'b0);
    wr(16'h2E, 8'h55, "R3");
    check("R3 open after restart", cfg_open, 1'b1);
    // R5 index, R6 ldn
    wr(16'h2E, 8'h07, "R5");
    rd(16'h2E, 8'h07, "R5 index readback");
    rd(16'h2F, 8'h00, "R4 locked write had no effect");
    wr(16'h2F, 8'h04, "R6");
    rd(16'h2F, 8'h04, "R6 ldn readback");
    check("R6 dev_ldn", dev_ldn, 8'h04);
    // R9 exit
    wr(16'h2E, 8'h02, "R9"); wr(16'h2F, 8'h05, "R9 wrong exit value");
    check("R9 stays open", cfg_open, 1'b1);
    wr(16'h2F, 8'h02, "R9 exit");
    check("R9 locked", cfg_open, 1'b0);
    rd(16'h2F, 8'hFF, "R4 data read after exit");
    // R2 exact key
    unlock("R2");
    check("R2 open", cfg_open, 1'b1);
    wr(16'h2E, 8'h07, "R6"); rd(16'h2F, 8'h04, "R6 ldn kept over lock");
    wr(16'h2F, 8'h07, "R6");
    // R7 chip id and revision
    wr(16'h2E, 8'h20, "R7"); rd(16'h2F, 8'h87, "R7 id high");
    wr(16'h2F, 8'h11, "R7 write ignored"); rd(16'h2F, 8'h87, "R7 id high after write");
    wr(16'h2E, 8'h21, "R7"); rd(16'h2F, 8'h28, "R7 id low");
    wr(16'h2E, 8'h22, "R7"); wr(16'h2F, 8'hFF, "R7"); rd(16'h2F, 8'h03, "R7 revision nibble");
    wr(16'h2E, 8'h10, "R9"); rd(16'h2F, 8'h00, "R9 unused global");
    // R8 device bank
    wr(16'h2E, 8'h71, "R8"); wr(16'h2F, 8'hC3, "R8 device write");
    rd(16'h2F, 8'h07 ^ 8'h71 ^ 8'h5A, "R8 device read");
    wr(16'h2E, 8'h30, "R8"); rd(16'h2F, 8'h07 ^ 8'h30 ^ 8'h5A, "R8 lowest device index");
    // R10 foreign address
    wr(16'h0080, 8'h02, "R10 foreign write");
    rd(16'h0080, 8'hFF, "R10 foreign read");
    rd(16'h2E, 8'h30, "R10 index untouched");
    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic [7:0] d;
      int r;
      r = int'($urandom % 8);
      a = (r < 3) ? 16'h2E : (r < 6) ? 16'h2F : 16'h0040;
      d = ($urandom % 4 == 0) ? 8'($urandom) : pool[$urandom % 8];
      if (!m_open && $urandom % 6 == 0) unlock("R2 random");
      else if ($urandom % 2 == 0) wr(a, d, "R8 random");
      else rd(a, exp_read(a), !m_open ? "R4 random" : (a != 16'h2F) ? "R5 random" : "R7 random");
      check("R9 random open state", cfg_open, m_open);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule